// File: doc/BRIEF.md
# Component Video Parallel Word Encoder

The block turns three component video sample streams into one 10-bit word stream at the master clock rate. The luma input is taken every second clock and the two colour-difference inputs every fourth clock. During active video the block interleaves them into repeating four-word groups: blue difference, luma, red difference, luma. The block counts words along the line and lines through the frame. Horizontal and frame drive pulses keep these counters aligned to the source. From the counters the block places a four-word timing reference at the end of active video and another just ahead of the first active sample.

Before a video sample reaches the output it can be rounded to a shorter word length, and it is then clamped. The clamp keeps the all-zeros and all-ones codes, and the codes next to them, free for timing references. Words in horizontal blanking, and every non-reference word of a vertical blanking line, carry blanking levels. When the ancillary strobe is high those words carry the ancillary input unchanged. A registered output selector chooses, for each word, between reference, video, ancillary and blanking data.

Top module: `comp_video_encoder`

## Requirements
- R1: While `rst_n` is low, `word_out` is 0x040. After release the word counter starts at 0 and the line counter at 0, so the first word out is 0x3FF, the first word of the line-start reference. The word for counter position h appears on `word_out` after the clock edge at which the counter holds h.
- R2: Counter positions 0 to 3 (end-of-active reference) output 0x3FF, 0x000, 0x000 and then a flag word with H=1.
- R3: Positions BLANK_WORDS-4 to BLANK_WORDS-1 (start-of-active reference) output 0x3FF, 0x000, 0x000 and then a flag word with H=0.
- R4: The flag word is {1, F, V, H, V^H, F^H, F^V, F^V^H, 0, 0}, from bit 9 down to bit 0.
- R5: F is 1 when line >= FIELD_LINES. V is 1 when the line index within its field is below VBLANK_LINES.
- R6: At positions BLANK_WORDS to H_TOTAL-1 of a line with V=0, a position with h mod 4 equal to 0, 1, 2 or 3 outputs Cb, Y, Cr or Y. The Cb word is the `cb_in` value taken at the edge where h mod 4 was 3. The Cr word is the `cr_in` value taken where h mod 4 was 1. Each Y word is the `y_in` value taken one edge before its own position.
- R7: `wl_sel` = d drops d low bits. The sample gets 2^(d-1) added (for d > 0) and the low d bits are cleared. A sum above 0x3FF saturates to 0x400 - 2^d.
- R8: After rounding, every video word is clamped to the range 0x004 to 0x3FB.
- R9: A word that is neither a reference nor video outputs 0x200 at even positions and 0x040 at odd positions while `anc_valid` is low. Vertical blanking lines fill their active region this way.
- R10: A non-reference, non-video word outputs `anc_data` unchanged while `anc_valid` is high. At reference and video positions `anc_valid` has no effect.
- R11: The word counter steps by one and wraps to 0 after H_TOTAL-1. An `hdrive` pulse forces it to 0 on the next edge. The line counter advances each time the word counter returns to 0 and wraps after 2*FIELD_LINES-1.
- R12: A `fdrive` pulse sets the line counter to 0 on the next edge, whether or not `hdrive` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock (master rate) |
| rst_n | input | 1 | Active-low synchronous reset |
| hdrive | input | 1 | Line-start pulse; restarts the word counter |
| fdrive | input | 1 | Frame-start pulse; restarts the line counter |
| y_in | input | 10 | Luma sample input |
| cb_in | input | 10 | Blue colour-difference sample input |
| cr_in | input | 10 | Red colour-difference sample input |
| wl_sel | input | 2 | Number of low bits removed by rounding (0 to 3) |
| anc_valid | input | 1 | Ancillary word present for the current blanking position |
| anc_data | input | 10 | Ancillary word, passed through unchanged |
| word_out | output | 10 | Multiplexed output word |

## Verification
The bench sweeps sample values so that every input code, including 0 to 3 and 0x3FC to 0x3FF, passes through every slot under all four rounding depths. A clamp bound that is off by one, or rounding applied after limiting, would then leak a reserved code or misround near the saturation point. The ancillary strobe is held high for whole lines. Any leak of ancillary data into reference or video words shows up as a wrong word at those positions. Lines run with and without `hdrive`, with a mid-line `hdrive`, with combined frame pulses and with a lone `fdrive`. A counter that ignored a drive, or double-stepped the line count when a pulse met the natural wrap, would put wrong F and V flags or misplaced references on the output.

// File: rtl/comp_video_enc_pkg.sv
`timescale 1ns/1ps
package comp_video_enc_pkg;

    localparam int WORD_W = 10;

    localparam logic [WORD_W-1:0] CODE_ONES  = 10'h3FF;
    localparam logic [WORD_W-1:0] CODE_ZERO  = 10'h000;
    localparam logic [WORD_W-1:0] VID_MIN    = 10'h004;
    localparam logic [WORD_W-1:0] VID_MAX    = 10'h3FB;
    localparam logic [WORD_W-1:0] BLANK_LUMA = 10'h040;
    localparam logic [WORD_W-1:0] BLANK_CHRO = 10'h200;

    typedef enum logic [2:0] {
        SEL_BLANK    = 3'd0,
        SEL_ANC      = 3'd1,
        SEL_VIDEO    = 3'd2,
        SEL_TRS_ONES = 3'd3,
        SEL_TRS_ZERO = 3'd4,
        SEL_TRS_XYZ  = 3'd5
    } word_sel_e;

    // Round half up to (WORD_W - drop) bits, saturating at the top.
    function automatic logic [WORD_W-1:0] round_word(input logic [WORD_W-1:0] v,
                                                     input logic [1:0] drop);
        logic [WORD_W:0]   sum;
        logic [WORD_W:0]   half;
        logic [WORD_W-1:0] mask;
        mask = CODE_ONES << drop;
        half = (drop == 2'd0) ? '0 : ((WORD_W+1)'(1) << (drop - 2'd1));
        sum  = {1'b0, v} + half;
        if (sum[WORD_W]) begin
            return CODE_ONES & mask;
        end
        return sum[WORD_W-1:0] & mask;
    endfunction

    function automatic logic [WORD_W-1:0] limit_word(input logic [WORD_W-1:0] v);
        if (v < VID_MIN) begin
            return VID_MIN;
        end
        if (v > VID_MAX) begin
            return VID_MAX;
        end
        return v;
    endfunction

    function automatic logic [WORD_W-1:0] flag_word(input logic f, input logic v,
                                                    input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
    endfunction

endpackage

// File: rtl/cve_timing.sv
`timescale 1ns/1ps
module cve_timing #(
    parameter int H_TOTAL      = 1728,
    parameter int FIELD_LINES  = 312,
    parameter int VBLANK_LINES = 24,
    localparam int FRAME_LINES = 2 * FIELD_LINES,
    localparam int HW          = $clog2(H_TOTAL),
    localparam int LW          = $clog2(FRAME_LINES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hdrive,
    input  logic          fdrive,
    output logic [HW-1:0] h_cnt,
    output logic [LW-1:0] line_cnt,
    output logic          f_flag,
    output logic          v_flag
);

    typedef struct packed {
        logic [HW-1:0] h;
        logic [LW-1:0] line;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic [LW-1:0] field_line;

    always_comb begin
        cnt_d = cnt_q;
        if (hdrive || (cnt_q.h == HW'(H_TOTAL - 1))) begin
            cnt_d.h    = '0;
            cnt_d.line = (cnt_q.line == LW'(FRAME_LINES - 1)) ? '0 : cnt_q.line + 1'b1;
        end else begin
            cnt_d.h = cnt_q.h + 1'b1;
        end
        if (fdrive) begin
            cnt_d.line = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        f_flag     = (cnt_q.line >= LW'(FIELD_LINES));
        field_line = f_flag ? (cnt_q.line - LW'(FIELD_LINES)) : cnt_q.line;
        v_flag     = (field_line < LW'(VBLANK_LINES));
    end

    assign h_cnt    = cnt_q.h;
    assign line_cnt = cnt_q.line;

endmodule

// File: rtl/cve_sampler.sv
`timescale 1ns/1ps
module cve_sampler
    import comp_video_enc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        phase,
    input  logic [WORD_W-1:0] y_in,
    input  logic [WORD_W-1:0] cb_in,
    input  logic [WORD_W-1:0] cr_in,
    input  logic [1:0]        wl_sel,
    output logic [WORD_W-1:0] vid_word
);

    // Component index: 0 = Cb, 1 = Y, 2 = Cr
    localparam int NCOMP = 3;

    logic [WORD_W-1:0] hold_d [NCOMP];
    logic [WORD_W-1:0] hold_q [NCOMP];
    logic [WORD_W-1:0] comp_in [NCOMP];
    logic [1:0]        load_phase [NCOMP];
    logic [1:0]        alt_phase [NCOMP];
    logic [WORD_W-1:0] raw;

    assign comp_in[0] = cb_in;
    assign comp_in[1] = y_in;
    assign comp_in[2] = cr_in;
    // Each hold loads one position ahead of the slot that reads it.
    assign load_phase[0] = 2'd3;
    assign load_phase[1] = 2'd0;
    assign load_phase[2] = 2'd1;
    assign alt_phase[0]  = 2'd3;
    assign alt_phase[1]  = 2'd2;
    assign alt_phase[2]  = 2'd1;

    for (genvar c = 0; c < NCOMP; c++) begin : g_hold
        always_comb begin
            hold_d[c] = hold_q[c];
            if ((phase == load_phase[c]) || (phase == alt_phase[c])) begin
                hold_d[c] = comp_in[c];
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold_q[c] <= (c == 1) ? BLANK_LUMA : BLANK_CHRO;
            end else begin
                hold_q[c] <= hold_d[c];
            end
        end
    end

    always_comb begin
        unique case (phase)
            2'd0:    raw = hold_q[0];
            2'd2:    raw = hold_q[2];
            default: raw = hold_q[1];
        endcase
        vid_word = limit_word(round_word(raw, wl_sel));
    end

endmodule

// File: rtl/comp_video_encoder.sv
`timescale 1ns/1ps
module comp_video_encoder
    import comp_video_enc_pkg::*;
#(
    parameter int ACTIVE_WORDS = 1440,
    parameter int BLANK_WORDS  = 288,
    parameter int FIELD_LINES  = 312,
    parameter int VBLANK_LINES = 24,
    localparam int H_TOTAL     = ACTIVE_WORDS + BLANK_WORDS,
    localparam int HW          = $clog2(H_TOTAL),
    localparam int LW          = $clog2(2 * FIELD_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hdrive,
    input  logic              fdrive,
    input  logic [WORD_W-1:0] y_in,
    input  logic [WORD_W-1:0] cb_in,
    input  logic [WORD_W-1:0] cr_in,
    input  logic [1:0]        wl_sel,
    input  logic              anc_valid,
    input  logic [WORD_W-1:0] anc_data,
    output logic [WORD_W-1:0] word_out
);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        word_sel_e         sel;
    } out_t;

    logic [HW-1:0]     h_cnt;
    logic [LW-1:0]     line_cnt;
    logic              f_flag;
    logic              v_flag;
    logic [WORD_W-1:0] vid_word;
    out_t              out_d, out_q;
    word_sel_e         sel_q;
    logic              in_eav, in_sav;
    logic [1:0]        trs_pos;

    cve_timing #(
        .H_TOTAL      (H_TOTAL),
        .FIELD_LINES  (FIELD_LINES),
        .VBLANK_LINES (VBLANK_LINES)
    ) u_timing (
        .clk      (clk),
        .rst_n    (rst_n),
        .hdrive   (hdrive),
        .fdrive   (fdrive),
        .h_cnt    (h_cnt),
        .line_cnt (line_cnt),
        .f_flag   (f_flag),
        .v_flag   (v_flag)
    );

    cve_sampler u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (h_cnt[1:0]),
        .y_in     (y_in),
        .cb_in    (cb_in),
        .cr_in    (cr_in),
        .wl_sel   (wl_sel),
        .vid_word (vid_word)
    );

    always_comb begin
        in_eav  = (h_cnt < HW'(4));
        in_sav  = (h_cnt >= HW'(BLANK_WORDS - 4)) && (h_cnt < HW'(BLANK_WORDS));
        trs_pos = h_cnt[1:0];
        out_d   = out_q;
        if (in_eav || in_sav) begin
            unique case (trs_pos)
                2'd0: begin
                    out_d.sel  = SEL_TRS_ONES;
                    out_d.word = CODE_ONES;
                end
                2'd3: begin
                    out_d.sel  = SEL_TRS_XYZ;
                    out_d.word = flag_word(f_flag, v_flag, in_eav);
                end
                default: begin
                    out_d.sel  = SEL_TRS_ZERO;
                    out_d.word = CODE_ZERO;
                end
            endcase
        end else if ((h_cnt >= HW'(BLANK_WORDS)) && !v_flag) begin
            out_d.sel  = SEL_VIDEO;
            out_d.word = vid_word;
        end else if (anc_valid) begin
            out_d.sel  = SEL_ANC;
            out_d.word = anc_data;
        end else begin
            out_d.sel  = SEL_BLANK;
            out_d.word = h_cnt[0] ? BLANK_LUMA : BLANK_CHRO;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '{word: BLANK_LUMA, sel: SEL_BLANK};
        end else begin
            out_q <= out_d;
        end
    end

    assign word_out = out_q.word;
    assign sel_q    = out_q.sel;

endmodule

// File: rtl/cve_checker.sv
`timescale 1ns/1ps
module cve_checker
    import comp_video_enc_pkg::*;
#(
    parameter int H_TOTAL = 1728,
    parameter int HW      = 11,
    parameter int LW      = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hdrive,
    input logic              fdrive,
    input logic [WORD_W-1:0] word_out,
    input word_sel_e         sel_q,
    input logic [HW-1:0]     h_cnt,
    input logic [LW-1:0]     line_cnt
);

    assert_hdrive_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hdrive |=> (h_cnt == '0));

    assert_natural_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!hdrive && (h_cnt == HW'(H_TOTAL - 1))) |=> (h_cnt == '0));

    assert_word_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!hdrive && (h_cnt != HW'(H_TOTAL - 1))) |=> (h_cnt == $past(h_cnt) + 1'b1));

    assert_frame_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
        fdrive |=> (line_cnt == '0));

    assert_video_clamped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == SEL_VIDEO) |-> ((word_out >= VID_MIN) && (word_out <= VID_MAX)));

    assert_trs_zero_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == SEL_TRS_ZERO) |-> (word_out == CODE_ZERO));

    assert_flag_protect_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == SEL_TRS_XYZ) |-> (word_out[9]
            && (word_out[5] == (word_out[7] ^ word_out[6]))
            && (word_out[4] == (word_out[8] ^ word_out[6]))
            && (word_out[3] == (word_out[8] ^ word_out[7]))
            && (word_out[2] == (word_out[8] ^ word_out[7] ^ word_out[6]))
            && (word_out[1:0] == 2'b00)));

endmodule

bind comp_video_encoder cve_checker #(
    .H_TOTAL (H_TOTAL),
    .HW      (HW),
    .LW      (LW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hdrive   (hdrive),
    .fdrive   (fdrive),
    .word_out (word_out),
    .sel_q    (sel_q),
    .h_cnt    (h_cnt),
    .line_cnt (line_cnt)
);

// File: tb/sim_comp_video_encoder.sv
`timescale 1ns/1ps
module sim_comp_video_encoder;

    localparam int ACT   = 16;
    localparam int BLK   = 12;
    localparam int FLD   = 8;
    localparam int VBL   = 2;
    localparam int TOT   = ACT + BLK;
    localparam int FRM   = 2 * FLD;
    localparam int NCYC  = 16000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hdrive = 1'b0;
    logic       fdrive = 1'b0;
    logic [9:0] y_in = '0;
    logic [9:0] cb_in = '0;
    logic [9:0] cr_in = '0;
    logic [1:0] wl_sel = '0;
    logic       anc_valid = 1'b0;
    logic [9:0] anc_data = '0;
    logic [9:0] word_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    comp_video_encoder #(
        .ACTIVE_WORDS (ACT),
        .BLANK_WORDS  (BLK),
        .FIELD_LINES  (FLD),
        .VBLANK_LINES (VBL)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .hdrive    (hdrive),
        .fdrive    (fdrive),
        .y_in      (y_in),
        .cb_in     (cb_in),
        .cr_in     (cr_in),
        .wl_sel    (wl_sel),
        .anc_valid (anc_valid),
        .anc_data  (anc_data),
        .word_out  (word_out)
    );

    task automatic check(input string tag, input logic [9:0] got, input logic [9:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic int rnd(input int v, input int d);
        int r;
        if (d == 0) return v;
        r = v + (1 << (d - 1));
        if (r > 1023) return 1024 - (1 << d);
        return r - (r % (1 << d));
    endfunction

    function automatic int lim(input int v);
        if (v < 4) return 4;
        if (v > 1019) return 1019;
        return v;
    endfunction

    function automatic int flagw(input int f, input int v, input int h);
        return 512 + f * 256 + v * 128 + h * 64 + ((v ^ h) << 5) + ((f ^ h) << 4)
             + ((f ^ v) << 3) + ((f ^ v ^ h) << 2);
    endfunction

    // Component value for slot h of bench line lc; comp 0 Cb, 1 Y, 2 Cr.
    function automatic int compval(input int lc, input int h, input int comp);
        int base;
        base = (lc * (ACT + 1) + (h - BLK)) & 1023;
        if (comp == 0) return base;
        if (comp == 1) return base ^ 'h2AA;
        return (~base) & 1023;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        int cur_h, cur_l, lcount;
        int nh, nl;
        int fv, vv, ph, raw, comp;
        bit have_exp, pend11, pend12, mid_done, fd_done, pend1;
        logic [9:0] exp_w;
        string exp_tag;

        cur_h = 0; cur_l = 0; lcount = 0;
        have_exp = 1'b0; pend11 = 1'b0; pend12 = 1'b0; pend1 = 1'b1;
        mid_done = 1'b0; fd_done = 1'b0;
        exp_w = '0; exp_tag = "";

        repeat (3) @(negedge clk);
        check("R1", word_out, 10'h040);
        anc_valid = 1'b1;
        anc_data  = 10'h155;
        @(negedge clk);
        check("R1", word_out, 10'h040);
        anc_valid = 1'b0;
        rst_n = 1'b1;

        for (int cyc = 0; cyc < NCYC; cyc++) begin
            if (have_exp) check(exp_tag, word_out, exp_w);

            // Stimulus for the coming edge
            wl_sel = 2'((cyc * 4) / NCYC);
            hdrive = 1'b0;
            fdrive = 1'b0;
            if ((cur_h == TOT - 1) && (lcount % 3 == 0)) hdrive = 1'b1;
            if ((cur_h == TOT - 1) && (cur_l == FRM - 1) && (lcount < 300)) begin
                hdrive = 1'b1;
                fdrive = 1'b1;
            end
            if (!mid_done && (lcount >= 450) && (cur_h == 10)) begin
                hdrive = 1'b1;
                mid_done = 1'b1;
            end
            if (!fd_done && (lcount >= 500) && (cur_l == 5) && (cur_h == 5)) begin
                fdrive = 1'b1;
                fd_done = 1'b1;
            end
            anc_valid = lcount[0];
            anc_data  = 10'((cyc * 37 + (cyc >> 3)) & 1023);
            cb_in = 10'(compval(lcount, cur_h + 1, 0));
            y_in  = 10'(compval(lcount, cur_h + 1, 1));
            cr_in = 10'(compval(lcount, cur_h + 1, 2));

            // Expected word for the current position
            fv = (cur_l >= FLD) ? 1 : 0;
            vv = (((fv != 0) ? cur_l - FLD : cur_l) < VBL) ? 1 : 0;
            if ((cur_h < 4) || ((cur_h >= BLK - 4) && (cur_h < BLK))) begin
                ph = cur_h % 4;
                exp_tag = (cur_h < 4) ? "R2" : "R3";
                if (ph == 0) exp_w = 10'h3FF;
                else if (ph == 3) begin
                    exp_w = 10'(flagw(fv, vv, (cur_h < 4) ? 1 : 0));
                    exp_tag = ((fv | vv) != 0) ? "R5" : "R4";
                end else exp_w = 10'h000;
                if (anc_valid) exp_tag = "R10";
            end else if ((cur_h >= BLK) && (vv == 0)) begin
                ph = cur_h % 4;
                comp = (ph == 0) ? 0 : ((ph == 2) ? 2 : 1);
                raw = compval(lcount, cur_h, comp);
                exp_w = 10'(lim(rnd(raw, int'(wl_sel))));
                if ((rnd(raw, int'(wl_sel)) < 4) || (rnd(raw, int'(wl_sel)) > 1019)) exp_tag = "R8";
                else if (wl_sel != 0) exp_tag = "R7";
                else exp_tag = "R6";
                if (anc_valid) exp_tag = "R10";
            end else if (anc_valid) begin
                exp_w = anc_data;
                exp_tag = "R10";
            end else begin
                exp_w = (cur_h % 2 == 1) ? 10'h040 : 10'h200;
                exp_tag = "R9";
            end
            if (pend1) begin exp_tag = "R1"; pend1 = 1'b0; end
            if (pend11 && (cur_h == 0)) begin exp_tag = "R11"; pend11 = 1'b0; end
            if (pend12 && (cur_h == 3)) begin exp_tag = "R12"; pend12 = 1'b0; end
            have_exp = 1'b1;

            // Advance the reference counters
            if (hdrive || (cur_h == TOT - 1)) begin
                nh = 0;
                nl = (cur_l == FRM - 1) ? 0 : cur_l + 1;
                lcount++;
                pend11 = !hdrive || (cur_h != TOT - 1) ? 1'b1 : pend11;
            end else begin
                nh = cur_h + 1;
                nl = cur_l;
            end
            if (fdrive) begin
                nl = 0;
                if (!hdrive) pend12 = 1'b1;
            end
            cur_h = nh;
            cur_l = nl;

            @(negedge clk);
        end
        check(exp_tag, word_out, exp_w);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule